// File: doc/BRIEF.md
# Streaming Gradient Product Stage

This block accepts a raster stream of 8-bit grayscale pixels, at most one per clock, and produces for every pixel position the three second-moment terms of its local gradient. These are the squared horizontal gradient, the squared vertical gradient and their cross product. Two line stores keep the previous two rows, so the central differences can be taken across the row above and the row below as well as across the left and right neighbours. Frame borders are handled by repeating the nearest pixel inside the frame. Each product is kept exact and fits an 18-bit signed word, so a smoothing stage built on 18-bit multipliers can take it without rounding.

The output row sequence runs one row behind the input. The block therefore emits the bottom row of a frame by itself during a short flush that follows the frame's last pixel. The frame geometry is fixed by the parameters `IMG_W` and `IMG_H`. After each row, the source leaves one idle cycle so the rightmost column can be closed. After each frame, it leaves `IMG_W`+2 idle cycles.

Top module: `gradprod_top`

## Requirements
- R1: With p(r,c) the unsigned 8-bit input pixel, the horizontal gradient is gx = p(r,c+1) - p(r,c-1), a 9-bit signed value, and `gxx_out` carries gx*gx.
- R2: The vertical gradient is gy = p(r+1,c) - p(r-1,c), a 9-bit signed value, and `gyy_out` carries gy*gy.
- R3: `gxy_out` carries gx*gy. All three outputs are exact 18-bit two's complement values, and the squares never exceed 65025.
- R4: A column index outside 0..IMG_W-1 is replaced by the nearest edge column before the difference is taken.
- R5: A row index outside 0..IMG_H-1 is replaced by the nearest edge row before the difference is taken.
- R6: Each frame of IMG_W*IMG_H input pixels yields exactly IMG_W*IMG_H outputs in raster order. The bottom row comes out through an internal flush, with no further input.
- R7: `sol_out` is high with the first output of every row and `sof_out` with the first output of a frame. Both are only ever high together with `vld_out`.
- R8: The reset `rst_n` is asynchronous and active low. While it is low and just after release, `vld_out`, `sol_out` and `sof_out` are low.
- R9: A new frame, marked by `sof_in`, may start `IMG_W`+2 idle cycles after the previous frame's last pixel. Its results do not depend on the previous frame's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 8 | Grayscale pixel, unsigned |
| vld_in | input | 1 | Pixel valid |
| sol_in | input | 1 | First pixel of a row |
| sof_in | input | 1 | First pixel of a frame |
| gxx_out | output | 18 | Squared horizontal gradient, signed |
| gyy_out | output | 18 | Squared vertical gradient, signed |
| gxy_out | output | 18 | Gradient cross product, signed |
| vld_out | output | 1 | Product triple valid |
| sol_out | output | 1 | First output of a row |
| sof_out | output | 1 | First output of a frame |

## Verification
The assertions assume that a frame is always exactly `IMG_W` by `IMG_H` pixels. They also assume that no pixel is offered while the block flushes: that is the single cycle after each row's last pixel and the `IMG_W`+1 cycles after a frame's last row closes. The per-frame output count and the idle-during-flush checks depend on that contract. The bench drives only whole frames, inserts exactly one idle cycle after every row, and starts the next frame no earlier than `IMG_W`+2 idle cycles after the last pixel. The back-to-back case uses exactly that minimum gap.

// File: rtl/gradprod_pkg.sv
package gradprod_pkg;

    // pixel and derived arithmetic widths
    localparam int PIX_W  = 8;
    localparam int GRAD_W = PIX_W + 1;
    localparam int PROD_W = 2 * GRAD_W;

    // gradient pair for one output position
    typedef struct packed {
        logic                     vld;
        logic                     sol;
        logic                     sof;
        logic signed [GRAD_W-1:0] gx;
        logic signed [GRAD_W-1:0] gy;
    } grad_t;

    // product triple for one output position
    typedef struct packed {
        logic                     vld;
        logic                     sol;
        logic                     sof;
        logic signed [PROD_W-1:0] xx;
        logic signed [PROD_W-1:0] yy;
        logic signed [PROD_W-1:0] xy;
    } prod_t;

endpackage

// File: rtl/line_store.sv
module line_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    // read of the old word and write of the new one share one address
    assign rdata = mem_q[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

endmodule

// File: rtl/grad_window.sv
module grad_window
    import gradprod_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 8,
    parameter int ROW_W = 4,
    parameter int COL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [PIX_W-1:0] top,
    input  logic [PIX_W-1:0] mid,
    input  logic [PIX_W-1:0] bot,
    output grad_t            grad_o
);

    typedef struct packed {
        logic [PIX_W-1:0]         m1;
        logic [PIX_W-1:0]         m2;
        logic signed [GRAD_W-1:0] gyp;
        grad_t                    g;
    } win_t;

    win_t w_d, w_q;

    logic [PIX_W-1:0]         up_sel, dn_sel, lt_sel, rt_sel;
    logic signed [GRAD_W-1:0] gy_now;

    always_comb begin
        w_d   = w_q;
        w_d.g = '0;
        // scan row r produces output row r-1; clamp above and below it
        up_sel = (row == ROW_W'(1))     ? mid : top;
        dn_sel = (row == ROW_W'(IMG_H)) ? mid : bot;
        gy_now = $signed({1'b0, dn_sel}) - $signed({1'b0, up_sel});
        // scan column c produces output column c-1; clamp left and right
        lt_sel = (col == COL_W'(1))     ? w_q.m1 : w_q.m2;
        rt_sel = (col == COL_W'(IMG_W)) ? w_q.m1 : mid;
        if (step) begin
            if ((row != '0) && (col != '0)) begin
                w_d.g.vld = 1'b1;
                w_d.g.sol = (col == COL_W'(1));
                w_d.g.sof = (col == COL_W'(1)) && (row == ROW_W'(1));
                w_d.g.gx  = $signed({1'b0, rt_sel}) - $signed({1'b0, lt_sel});
                w_d.g.gy  = w_q.gyp;
            end
            if (col < COL_W'(IMG_W)) begin
                w_d.m2  = w_q.m1;
                w_d.m1  = mid;
                w_d.gyp = gy_now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign grad_o = w_q.g;

endmodule

// File: rtl/prod_stage.sv
module prod_stage
    import gradprod_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  grad_t grad_i,
    output prod_t prod_o
);

    localparam int N_PROD = 3;

    logic signed [GRAD_W-1:0] opa [N_PROD];
    logic signed [GRAD_W-1:0] opb [N_PROD];
    logic signed [PROD_W-1:0] mul [N_PROD];
    prod_t p_d, p_q;

    // lane 0: gx*gx, lane 1: gy*gy, lane 2: gx*gy
    for (genvar k = 0; k < N_PROD; k++) begin : g_lane
        assign opa[k] = (k == 1) ? grad_i.gy : grad_i.gx;
        assign opb[k] = (k == 0) ? grad_i.gx : grad_i.gy;
        assign mul[k] = PROD_W'(opa[k]) * PROD_W'(opb[k]);
    end

    always_comb begin
        p_d     = '0;
        p_d.vld = grad_i.vld;
        p_d.sol = grad_i.sol;
        p_d.sof = grad_i.sof;
        p_d.xx  = mul[0];
        p_d.yy  = mul[1];
        p_d.xy  = mul[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign prod_o = p_q;

endmodule

// File: rtl/gradprod_top.sv
module gradprod_top
    import gradprod_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PIX_W-1:0]         pix_in,
    input  logic                     vld_in,
    input  logic                     sol_in,
    input  logic                     sof_in,
    output logic signed [PROD_W-1:0] gxx_out,
    output logic signed [PROD_W-1:0] gyy_out,
    output logic signed [PROD_W-1:0] gxy_out,
    output logic                     vld_out,
    output logic                     sol_out,
    output logic                     sof_out
);

    localparam int COL_W  = $clog2(IMG_W + 1);
    localparam int ROW_W  = $clog2(IMG_H + 1);
    localparam int ADR_W  = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int N_LINE = 2;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             flush;
    } scan_t;

    scan_t scan_d, scan_q;

    logic             accept, step, in_line, flush_active;
    logic [ROW_W-1:0] s_row;
    logic [COL_W-1:0] s_col;
    logic [ADR_W-1:0] lb_addr;
    logic [PIX_W-1:0] bot;
    logic [PIX_W-1:0] lb_wr [N_LINE];
    logic [PIX_W-1:0] lb_rd [N_LINE];
    grad_t            grad;
    prod_t            prod;

    // scan position: columns 0..IMG_W (IMG_W closes a row),
    // rows 0..IMG_H (IMG_H is the self-generated bottom flush row)
    always_comb begin
        accept  = vld_in && !scan_q.flush;
        step    = accept || scan_q.flush;
        s_col   = (accept && (sof_in || sol_in)) ? '0 : scan_q.col;
        s_row   = (accept && sof_in) ? '0 : scan_q.row;
        in_line = (s_col < COL_W'(IMG_W));
        lb_addr = in_line ? ADR_W'(s_col) : '0;
        scan_d  = scan_q;
        if (step) begin
            if (!in_line) begin
                if (s_row == ROW_W'(IMG_H)) begin
                    scan_d = '0;
                end else begin
                    scan_d.row   = s_row + ROW_W'(1);
                    scan_d.col   = '0;
                    scan_d.flush = (s_row == ROW_W'(IMG_H - 1));
                end
            end else begin
                scan_d.row   = s_row;
                scan_d.col   = s_col + COL_W'(1);
                scan_d.flush = scan_q.flush || (s_col == COL_W'(IMG_W - 1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q <= '0;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign flush_active = scan_q.flush;

    // the flush row repeats the last stored row as the row below it
    assign bot      = scan_q.flush ? lb_rd[0] : pix_in;
    assign lb_wr[0] = bot;
    assign lb_wr[1] = lb_rd[0];

    for (genvar k = 0; k < N_LINE; k++) begin : g_line
        line_store #(
            .DEPTH(IMG_W),
            .AW   (ADR_W),
            .DW   (PIX_W)
        ) u_line (
            .clk  (clk),
            .we   (step && in_line),
            .addr (lb_addr),
            .wdata(lb_wr[k]),
            .rdata(lb_rd[k])
        );
    end

    grad_window #(
        .IMG_W(IMG_W),
        .IMG_H(IMG_H),
        .ROW_W(ROW_W),
        .COL_W(COL_W)
    ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .row   (s_row),
        .col   (s_col),
        .top   (lb_rd[1]),
        .mid   (lb_rd[0]),
        .bot   (bot),
        .grad_o(grad)
    );

    prod_stage u_prod (
        .clk   (clk),
        .rst_n (rst_n),
        .grad_i(grad),
        .prod_o(prod)
    );

    assign gxx_out = prod.xx;
    assign gyy_out = prod.yy;
    assign gxy_out = prod.xy;
    assign vld_out = prod.vld;
    assign sol_out = prod.sol;
    assign sof_out = prod.sof;

endmodule

// File: rtl/gradprod_chk.sv
module gradprod_chk
    import gradprod_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     vld_in,
    input logic                     flush,
    input logic signed [PROD_W-1:0] gxx,
    input logic signed [PROD_W-1:0] gyy,
    input logic signed [PROD_W-1:0] gxy,
    input logic                     vld,
    input logic                     sol,
    input logic                     sof
);

    localparam int MAXSQ   = (2**PIX_W - 1) * (2**PIX_W - 1);
    localparam int FRAME_N = IMG_W * IMG_H;
    localparam int WIDE_W  = 2 * PROD_W;

    logic signed [WIDE_W-1:0] sq_prod, cross_sq;
    logic [31:0]              out_cnt_q;
    logic                     seen_q;

    assign sq_prod  = WIDE_W'(gxx) * WIDE_W'(gyy);
    assign cross_sq = WIDE_W'(gxy) * WIDE_W'(gxy);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_cnt_q <= '0;
            seen_q    <= 1'b0;
        end else if (vld) begin
            out_cnt_q <= sof ? 32'd1 : out_cnt_q + 32'd1;
            seen_q    <= seen_q || sof;
        end
    end

    // R3
    cross_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (sq_prod == cross_sq));

    // R1
    xx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (int'(gxx) >= 0 && int'(gxx) <= MAXSQ));

    // R2
    yy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (int'(gyy) >= 0 && int'(gyy) <= MAXSQ));

    // R7
    sof_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (sol && vld));

    // R7
    sol_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sol |-> vld);

    // R6
    frame_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && seen_q) |-> (out_cnt_q == 32'(FRAME_N)));

    // R9
    quiet_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !vld_in);

    // R8
    always_comb begin
        if (!rst_n) begin
            reset_idle_chk: assert (!vld && !sol && !sof);
        end
    end

endmodule

bind gradprod_top gradprod_chk #(
    .IMG_W(IMG_W),
    .IMG_H(IMG_H)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_in(vld_in),
    .flush (flush_active),
    .gxx   (gxx_out),
    .gyy   (gyy_out),
    .gxy   (gxy_out),
    .vld   (vld_out),
    .sol   (sol_out),
    .sof   (sof_out)
);

// File: tb/gradprod_top_bench.sv
module gradprod_top_bench;
    import gradprod_pkg::*;

    localparam int TW = 6;
    localparam int TH = 5;
    localparam int N  = TW * TH;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [PIX_W-1:0]         pix_in = '0;
    logic                     vld_in = 1'b0;
    logic                     sol_in = 1'b0;
    logic                     sof_in = 1'b0;
    logic signed [PROD_W-1:0] gxx_out, gyy_out, gxy_out;
    logic                     vld_out, sol_out, sof_out;

    int n_chk  = 0;
    int n_fail = 0;
    int got_n  = 0;
    int img   [2][TH][TW];
    int g_xx  [2*N];
    int g_yy  [2*N];
    int g_xy  [2*N];
    int g_sol [2*N];
    int g_sof [2*N];
    int seed  = 32'h1d2c3b4a;

    always #2 clk = ~clk;

    gradprod_top #(.IMG_W(TW), .IMG_H(TH)) u_gradprod_top (
        .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .vld_in(vld_in),
        .sol_in(sol_in), .sof_in(sof_in), .gxx_out(gxx_out),
        .gyy_out(gyy_out), .gxy_out(gxy_out), .vld_out(vld_out),
        .sol_out(sol_out), .sof_out(sof_out));

    always @(negedge clk) begin
        if (rst_n && vld_out) begin
            if (got_n < 2*N) begin
                g_xx[got_n]  = int'(gxx_out);
                g_yy[got_n]  = int'(gyy_out);
                g_xy[got_n]  = int'(gxy_out);
                g_sol[got_n] = int'(sol_out);
                g_sof[got_n] = int'(sof_out);
            end
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int px(input int f, input int r, input int c);
        int rr = (r < 0) ? 0 : ((r > TH-1) ? TH-1 : r);
        int cc = (c < 0) ? 0 : ((c > TW-1) ? TW-1 : c);
        return img[f][rr][cc];
    endfunction

    function automatic int next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >>> 17);
        seed = seed ^ (seed << 5);
        return seed & 255;
    endfunction

    // kind: 0 column ramp, 1 row ramp, 2 random, 3 step edge, 4 corner spots, 5 flat white
    task automatic fill(input int f, input int kind);
        for (int r = 0; r < TH; r++) begin
            for (int c = 0; c < TW; c++) begin
                case (kind)
                    0: img[f][r][c] = c * 40;
                    1: img[f][r][c] = r * 50;
                    2: img[f][r][c] = next_rand();
                    3: img[f][r][c] = (r >= 2 && c >= 3) ? 255 : 0;
                    4: img[f][r][c] = ((r == 0 || r == TH-1) && (c == 0 || c == TW-1)) ? 255 : 0;
                    default: img[f][r][c] = 255;
                endcase
            end
        end
    endtask

    // one idle cycle after each row; gap idle cycles after the frame
    task automatic drive_frame(input int f, input int gap);
        for (int r = 0; r < TH; r++) begin
            for (int c = 0; c < TW; c++) begin
                @(posedge clk); #1;
                vld_in = 1'b1;
                pix_in = PIX_W'(img[f][r][c]);
                sol_in = (c == 0);
                sof_in = (c == 0) && (r == 0);
            end
            @(posedge clk); #1;
            vld_in = 1'b0; sol_in = 1'b0; sof_in = 1'b0; pix_in = 8'hA5;
        end
        repeat (gap - 1) @(posedge clk);
    endtask

    task automatic check_frame(input int f, input int base, input string name);
        for (int i = 0; i < N; i++) begin
            int r = i / TW;
            int c = i % TW;
            int gx = px(f, r, c+1) - px(f, r, c-1);
            int gy = px(f, r+1, c) - px(f, r-1, c);
            string hx = (c == 0 || c == TW-1) ? "R4" : "R1";
            string hy = (r == 0 || r == TH-1) ? "R5" : "R2";
            chk(g_xx[base+i] == gx*gx, $sformatf("%s %s gxx r%0d c%0d", hx, name, r, c), g_xx[base+i], gx*gx);
            chk(g_yy[base+i] == gy*gy, $sformatf("%s %s gyy r%0d c%0d", hy, name, r, c), g_yy[base+i], gy*gy);
            chk(g_xy[base+i] == gx*gy, $sformatf("R3 %s gxy r%0d c%0d", name, r, c), g_xy[base+i], gx*gy);
            chk(g_sol[base+i] == int'(c == 0) && g_sof[base+i] == int'(i == 0),
                $sformatf("R7 %s markers r%0d c%0d", name, r, c),
                g_sol[base+i]*2 + g_sof[base+i], int'(c == 0)*2 + int'(i == 0));
        end
    endtask

    task automatic run_single(input int kind, input string name);
        fill(0, kind);
        got_n = 0;
        drive_frame(0, TW + 10);
        // R6: exactly one output per pixel, bottom row included
        chk(got_n == N, $sformatf("R6 %s output count", name), got_n, N);
        check_frame(0, 0, name);
    endtask

    task automatic t_reset();
        vld_in = 1'b1; pix_in = 8'hFF; sof_in = 1'b1; sol_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R8: outputs idle while held in reset
        chk(!vld_out && !sol_out && !sof_out, "R8 in reset", int'(vld_out), 0);
        vld_in = 1'b0; sof_in = 1'b0; sol_in = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!vld_out && !sol_out && !sof_out, "R8 after release", int'(vld_out), 0);
    endtask

    task automatic t_back_to_back();
        fill(0, 5);
        fill(1, 4);
        got_n = 0;
        // R9: minimum gap of TW+2 idle cycles between frames
        drive_frame(0, TW + 2);
        drive_frame(1, TW + 10);
        chk(got_n == 2*N, "R6 back-to-back output count", got_n, 2*N);
        check_frame(0, 0, "R9 first");
        check_frame(1, N, "R9 second");
    endtask

    initial begin
        t_reset();
        run_single(0, "column ramp");
        run_single(1, "row ramp");
        run_single(2, "random");
        run_single(3, "step edge");
        run_single(4, "corner spots");
        t_back_to_back();
        run_single(2, "random again");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule